// File: doc/BRIEF.md
# Virtual Countdown Timer Control and Interrupt

This block is the control and interrupt stage of one channel of a generic compare/countdown timer. It watches a free-running 64-bit system count and holds a 64-bit compare value. It computes whether the timer has fired and drives a level interrupt from that result. Software reaches it through a single 64-bit register port. A two-bit select picks one of three views: the control word, the compare value, or a 32-bit countdown view derived from the compare value and the current count.

The control word has three bits. One turns the timer on, one masks the interrupt, and one is a read-only status flag. The status flag reports the fired condition and does not look at the mask. Turning the timer off only silences the status and the interrupt. The compare value is kept, so the countdown view goes on falling as the count advances. The interrupt leaves a flop and follows the timer state one clock late.

Top module: `vtmr_core`

## Requirements
- R1: After reset the on bit, the mask bit and the compare value are 0, and `irq_o` is low.
- R2: The select encoding is 0 = control word, 1 = compare value, 2 = countdown view, 3 = unused. A write to the control word sets the on bit from bit 0 and the mask bit from bit 1. A read of the control word returns on in bit 0, mask in bit 1 and status in bit 2, with bits 63 to 3 always 0.
- R3: Bit 2 of the control word is read-only, and writing it changes no readable state.
- R4: While the timer is on, status is 1 exactly when the count is greater than or equal to the compare value in an unsigned 64-bit comparison. The mask bit has no effect on status.
- R5: `irq_o` is registered. In each cycle it equals (status AND NOT mask) as it stood in the previous cycle.
- R6: While the timer is off, status reads 0 and `irq_o` is low from the cycle after the timer was turned off.
- R7: A read of the countdown view returns the low 32 bits of (compare value minus count) with bits 63 to 32 set to 0. The value keeps falling as the count advances while the timer is off.
- R8: A write to the countdown view loads the compare value with the count plus the sign-extended low 32 bits of the write data. Bits 63 to 32 of the write data are ignored.
- R9: A write to the compare value stores all 64 bits, and a read returns them unchanged.
- R10: A read with select 3 returns 0, and a write with select 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 64 | Free-running system count |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register view select |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for the selected view (combinational) |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
Two things can happen in the same cycle: a register write that changes the on or mask bits, and the interrupt flop capturing the previous state. The bench writes the control word while the fire condition already holds. It then checks that `irq_o` still shows the old masked or enabled state in the first window after the write and shows the new state one window later. A second case makes a countdown write and a read of the resulting compare value meet the same count value. This checks that the load uses the count present during the write.

// File: rtl/vtmr_pkg.sv
package vtmr_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_DOWN = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int BIT_ON   = 0;
    localparam int BIT_MSK  = 1;
    localparam int BIT_STAT = 2;
    localparam int CTRL_W   = 3;
endpackage

// File: rtl/vtmr_regs.sv
module vtmr_regs
    import vtmr_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int DOWN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_en_i,
    input  logic [1:0]       sel_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             on_o,
    output logic             msk_o,
    output logic [CNT_W-1:0] cmp_o
);
    localparam int EXT_W = CNT_W - DOWN_W;

    typedef struct packed {
        logic             on;
        logic             msk;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t st_d, st_q;
    logic [CNT_W-1:0] down_ext;

    always_comb begin
        down_ext = {{EXT_W{wdata_i[DOWN_W-1]}}, wdata_i[DOWN_W-1:0]};
        st_d = st_q;
        if (wr_en_i) begin
            case (reg_sel_e'(sel_i))
                SEL_CTRL: begin
                    st_d.on  = wdata_i[BIT_ON];
                    st_d.msk = wdata_i[BIT_MSK];
                end
                SEL_CMP:  st_d.cmp = wdata_i;
                SEL_DOWN: st_d.cmp = cnt_i + down_ext;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_o  = st_q.on;
    assign msk_o = st_q.msk;
    assign cmp_o = st_q.cmp;

    // R2: control write lands in the on and mask bits
    p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == 2'd0) |=> (on_o == $past(wdata_i[0]) && msk_o == $past(wdata_i[1])));

    // R10: compare value holds when no write targets it
    p_cmp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || sel_i == 2'd0 || sel_i == 2'd3) |=> $stable(cmp_o));

    // R3: control bits only move on a control write
    p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && sel_i == 2'd0) |=> ($stable(on_o) && $stable(msk_o)));
endmodule

// File: rtl/vtmr_fire.sv
module vtmr_fire #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             on_i,
    input  logic             msk_i,
    output logic             stat_o,
    output logic             irq_o
);
    typedef struct packed {
        logic irq;
    } fire_t;

    fire_t fr_d, fr_q;
    logic  met;

    always_comb begin
        met       = (cnt_i >= cmp_i);
        stat_o    = on_i & met;
        fr_d.irq  = stat_o & ~msk_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign irq_o = fr_q.irq;

    // R5: a mask seen in one cycle keeps the interrupt low in the next
    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msk_i |=> !irq_o);

    // R6: an off timer keeps the interrupt low in the next cycle
    p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> !irq_o);

    // R5: interrupt only rises after status was up
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(stat_o));
endmodule

// File: rtl/vtmr_core.sv
module vtmr_core
    import vtmr_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int DOWN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_en_i,
    input  logic [1:0]       sel_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_o
);
    localparam int HI_W = CNT_W - DOWN_W;

    logic             on, msk, stat;
    logic [CNT_W-1:0] cmp;
    logic [DOWN_W-1:0] down_lo;

    vtmr_regs #(.CNT_W(CNT_W), .DOWN_W(DOWN_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en_i(wr_en_i),
        .sel_i(sel_i), .wdata_i(wdata_i),
        .on_o(on), .msk_o(msk), .cmp_o(cmp)
    );

    vtmr_fire #(.CNT_W(CNT_W)) fire_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_i(cmp),
        .on_i(on), .msk_i(msk), .stat_o(stat), .irq_o(irq_o)
    );

    always_comb begin
        down_lo = cmp[DOWN_W-1:0] - cnt_i[DOWN_W-1:0];
        rdata_o = '0;
        case (reg_sel_e'(sel_i))
            SEL_CTRL: begin
                rdata_o[BIT_ON]   = on;
                rdata_o[BIT_MSK]  = msk;
                rdata_o[BIT_STAT] = stat;
            end
            SEL_CMP:  rdata_o = cmp;
            SEL_DOWN: rdata_o = {{HI_W{1'b0}}, down_lo};
            default:  rdata_o = '0;
        endcase
    end

    // R7: with compare held and count stepping by one, the countdown view drops by one
    p_down_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd2 && $past(sel_i == 2'd2) && !$past(wr_en_i) && cnt_i == $past(cnt_i) + 1'b1)
        |-> rdata_o[DOWN_W-1:0] == $past(rdata_o[DOWN_W-1:0]) - 1'b1);

    // R6: an off timer never shows status on a control read
    p_stat_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd0 && !rdata_o[0]) |-> !rdata_o[2]);
endmodule

// File: tb/vtmr_core_tb_top.sv
module vtmr_core_tb_top;
    typedef struct {
        int          stamp;
        bit          is_rd;
        logic [63:0] exp;
        string       req;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] cnt = 64'd10;
    logic        wr_en = 0;
    logic [1:0]  sel = 2'd0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        irq;

    int    cyc = 0;
    int    n_run = 0, n_fail = 0;
    bit    done = 0;
    item_t sb[$];

    bit          m_on = 0, m_msk = 0;
    logic [63:0] m_cmp = '0;

    vtmr_core dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .wr_en_i(wr_en),
        .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit m_stat();
        return m_on && (cnt >= m_cmp);
    endfunction

    function automatic logic [63:0] m_ctl();
        return {61'b0, m_stat(), m_msk, m_on};
    endfunction

    // driver tasks: called right after a falling edge
    task automatic wr(input logic [1:0] s, input logic [63:0] d);
        wr_en = 1; sel = s; wdata = d;
        case (s)
            2'd0: begin m_on = d[0]; m_msk = d[1]; end
            2'd1: m_cmp = d;
            2'd2: m_cmp = cnt + {{32{d[31]}}, d[31:0]};
            default: ;
        endcase
        @(negedge clk);
        wr_en = 0; wdata = '0;
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            cnt = cnt + 64'd1;
            @(negedge clk);
        end
    endtask

    task automatic exp_rd(input logic [1:0] s, input logic [63:0] e, input string r);
        item_t it;
        sel = s;
        it.stamp = cyc; it.is_rd = 1; it.exp = e; it.req = r;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_irq(input int dly, input bit e, input string r);
        item_t it;
        it.stamp = cyc + dly; it.is_rd = 0; it.exp = {63'b0, e}; it.req = r;
        sb.push_back(it);
    endtask

    // monitor: compares due items shortly after each falling edge
    always begin
        @(negedge clk);
        #2;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].stamp == cyc) begin
                logic [63:0] act;
                act = sb[i].is_rd ? rdata : {63'b0, irq};
                n_run++;
                if (act !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s %s actual=%h expected=%h", sb[i].req,
                             sb[i].is_rd ? "rdata" : "irq", act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            if (sb.size() != 0) begin
                n_fail += sb.size();
                $display("FAIL leftover %0d unchecked items actual=%0d expected=0", sb.size(), sb.size());
            end
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(10 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        exp_irq(0, 0, "R1");
        exp_rd(2'd0, 64'd0, "R1");
        exp_rd(2'd1, 64'd0, "R1");
        // R9: full compare write
        wr(2'd1, 64'hA5A5_0000_0000_03E8);
        exp_rd(2'd1, 64'hA5A5_0000_0000_03E8, "R9");
        wr(2'd1, 64'd1000);
        exp_rd(2'd1, 64'd1000, "R9");
        // R2 / R3: all-ones write, upper bits and status stay 0
        wr(2'd0, '1);
        exp_rd(2'd0, 64'd3, "R2");
        wr(2'd0, 64'h4);
        exp_rd(2'd0, 64'd0, "R3");
        // R4: on and masked, condition met, status ignores mask
        wr(2'd0, 64'h3);
        wr(2'd1, 64'd5);
        exp_irq(1, 0, "R5");
        exp_rd(2'd0, m_ctl(), "R4");
        // R5: unmask while condition holds, one cycle of latency
        wr(2'd0, 64'h1);
        exp_irq(0, 0, "R5");
        exp_irq(1, 1, "R5");
        adv(1);
        exp_irq(0, 1, "R5");
        exp_rd(2'd0, 64'h5, "R4");
        // R6: turn off, irq drops a cycle later, status reads 0
        wr(2'd0, 64'h0);
        exp_irq(0, 1, "R6");
        exp_irq(1, 0, "R6");
        exp_rd(2'd0, 64'd0, "R6");
        // R8 / R7: countdown load then keeps falling while off
        wr(2'd2, 64'd100);
        exp_rd(2'd2, 64'd100, "R8");
        exp_rd(2'd1, m_cmp, "R8");
        adv(5);
        exp_rd(2'd2, 64'd95, "R7");
        exp_irq(0, 0, "R6");
        // R8: negative load, upper write bits ignored
        wr(2'd2, 64'h1234_5678_FFFF_FFFE);
        exp_rd(2'd1, m_cmp, "R8");
        exp_rd(2'd2, 64'h0000_0000_FFFF_FFFE, "R8");
        wr(2'd0, 64'h1);
        exp_irq(1, 1, "R4");
        exp_rd(2'd0, 64'h5, "R4");
        // R4: unsigned compare with top bit set is not met
        wr(2'd1, 64'h8000_0000_0000_0000);
        exp_irq(1, 0, "R4");
        exp_rd(2'd0, 64'h1, "R4");
        // R4: boundary, one below then equal
        wr(2'd1, cnt + 64'd1);
        exp_rd(2'd0, 64'h1, "R4");
        adv(1);
        exp_irq(1, 1, "R4");
        exp_rd(2'd0, 64'h5, "R4");
        // R10: unused select
        wr(2'd3, '1);
        exp_rd(2'd3, 64'd0, "R10");
        exp_rd(2'd1, m_cmp, "R10");
        exp_rd(2'd0, m_ctl(), "R10");
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule